// File: doc/BRIEF.md
# Branch Condition Evaluator and Program-Counter Sequencer

This block resolves every control-transfer instruction of an 8-bit processor with a 16-bit address space. On each cycle that `issue` is high it takes the opcode, the flag byte, the loop-count register B, the current program counter, the two operand bytes already fetched, the HL pair and the word just read from the stack. One clock later it presents the branch outcome: whether control transfers, the next program counter, how many operand bytes the instruction consumed, whether the stack must be pushed (and with which return address) or popped, and the new value of B.

The block covers absolute jumps, jumps through HL, signed relative jumps, the decrement-B loop branch, calls, returns and fixed-vector restarts. One 3-bit condition field is shared by conditional jumps, calls and returns. Relative jumps use a 2-bit subset of it. Stack memory, instruction fetch and the arithmetic unit sit outside. Opcodes that are not control transfers fall straight through to the next byte.

A small state machine tracks whether a result is on show. `ST_IDLE` means no result is presented. `ST_SHOW` means a registered result is valid. The transitions are `T_ISSUE`, from `ST_IDLE` to `ST_SHOW` when `issue` is high. `T_NEXT` keeps the machine in `ST_SHOW` when `issue` is high again. `T_DRAIN` goes from `ST_SHOW` to `ST_IDLE` when `issue` is low. `T_WAIT` keeps the machine in `ST_IDLE` when `issue` is low.

Top module: `branch_sequencer`

## Requirements
- R1: After reset, `res_valid`, `taken`, `push_req` and `pop_req` are 0, and `next_pc`, `push_addr`, `b_out` and `opnd_bytes` are 0.
- R2: A conditional absolute jump `11ccc010` tests the condition c = opcode[5:3]. The conditions for c = 0..7 are: Z clear, Z set, C clear, C set, P clear, P set, S clear, S set. The flag bits are S = flags[7], Z = flags[6], P = flags[2] and C = flags[0]. The unconditional jump is 0xC3. A taken jump loads `operand`.
- R3: An absolute jump or call, conditional or not, reports `opnd_bytes` = 2 whether or not it is taken. When it is not taken, `next_pc` = pc+3 and neither push nor pop is requested.
- R4: A relative jump is 0x18 (always) or `001cc000`, where cc = opcode[4:3] selects Z clear, Z set, C clear or C set. It consumes 1 byte. When taken, `next_pc` = pc+2+sign-extended operand[7:0]. Otherwise `next_pc` = pc+2.
- R5: The loop branch 0x10 gives `b_out` = B−1, wrapping modulo 256. It is taken, to pc+2+sign-extended operand[7:0], only when the new B is nonzero. Otherwise `next_pc` = pc+2.
- R6: A restart `11ttt111` is always taken. It raises `push_req` with `push_addr` = pc+1 and sets `next_pc` = ttt×8 (0x00 to 0x38).
- R7: A call, 0xCD or `11ccc100` with the R2 conditions, raises `push_req` with `push_addr` = pc+3 and loads `operand` only when taken.
- R8: A return, 0xC9 or `11ccc000` with the R2 conditions, raises `pop_req` and sets `next_pc` = `pop_addr` only when taken. Otherwise `next_pc` = pc+1 with no pop.
- R9: 0xE9 is always taken. It sets `next_pc` = `hl` with `opnd_bytes` = 0 and no stack request.
- R10: Any other opcode is not taken. It sets `next_pc` = pc+1 and `opnd_bytes` = 0, makes no stack request, and leaves `b_out` equal to B. Only 0x10 changes B. When there is no push, `push_addr` is 0.
- R11: Results appear one clock after the edge that samples `issue` high, with `res_valid` = 1. After an edge with `issue` low, `res_valid`, `taken`, `push_req` and `pop_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Inputs hold a branch-class instruction to resolve |
| opcode | input | 8 | Instruction opcode |
| flags | input | 8 | Flag byte (S=7, Z=6, P=2, C=0) |
| reg_b | input | 8 | Current value of B |
| pc | input | ADDR_W | Address of the instruction's first byte |
| operand | input | ADDR_W | Fetched operand bytes; low byte is the displacement |
| hl | input | ADDR_W | HL register pair |
| pop_addr | input | ADDR_W | Word at the top of the stack |
| res_valid | output | 1 | Result registers hold a new outcome |
| taken | output | 1 | Control transfers away from the fall-through address |
| next_pc | output | ADDR_W | Program counter for the next instruction |
| opnd_bytes | output | 2 | Operand bytes consumed (0, 1 or 2) |
| push_req | output | 1 | Push `push_addr` onto the stack |
| pop_req | output | 1 | Pop the stack into the program counter |
| push_addr | output | ADDR_W | Return address to push |
| b_out | output | 8 | New value of B |

## Verification
A wrong decode class or a wrong condition selection shows as a `taken`, `next_pc` or stack-request mismatch in the very cycle after the offending issue. A stuck or wrong state in the result machine shows as `res_valid` staying high or low one cycle after `issue` changes. Because every result is one register deep, any corruption surfaces at the ports within a single clock. The reference model compares every field on every cycle, so nothing has to accumulate before it is seen.

// File: rtl/brseq_pkg.sv
package brseq_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_JP,
        K_JR,
        K_DJNZ,
        K_CALL,
        K_RET,
        K_RST,
        K_JPHL
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       cond_en;
        logic [2:0] cond;
    } dec_t;

    typedef enum logic {
        ST_IDLE,
        ST_SHOW
    } state_e;

endpackage

// File: rtl/brseq_decode.sv
module brseq_decode
    import brseq_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);
    always_comb begin
        dec.kind    = K_NONE;
        dec.cond_en = 1'b0;
        dec.cond    = op[5:3];
        if (op == 8'hC3) begin
            dec.kind = K_JP;
        end else if (op == 8'hE9) begin
            dec.kind = K_JPHL;
        end else if (op == 8'hCD) begin
            dec.kind = K_CALL;
        end else if (op == 8'hC9) begin
            dec.kind = K_RET;
        end else if (op == 8'h18) begin
            dec.kind = K_JR;
        end else if (op == 8'h10) begin
            dec.kind = K_DJNZ;
        end else if (op[7:6] == 2'b11) begin
            case (op[2:0])
                3'b010: begin dec.kind = K_JP;   dec.cond_en = 1'b1; end
                3'b100: begin dec.kind = K_CALL; dec.cond_en = 1'b1; end
                3'b000: begin dec.kind = K_RET;  dec.cond_en = 1'b1; end
                3'b111: begin dec.kind = K_RST; end
                default: dec.kind = K_NONE;
            endcase
        end else if (op[7:5] == 3'b001 && op[2:0] == 3'b000) begin
            dec.kind    = K_JR;
            dec.cond_en = 1'b1;
            dec.cond    = {1'b0, op[4:3]};
        end
    end
endmodule

// File: rtl/brseq_cond.sv
module brseq_cond #(
    parameter int S_BIT = 7,
    parameter int Z_BIT = 6,
    parameter int P_BIT = 2,
    parameter int C_BIT = 0
) (
    input  logic       cond_en,
    input  logic [2:0] cond,
    input  logic [7:0] flags,
    output logic       ok
);
    logic sel;

    always_comb begin
        unique case (cond)
            3'd0: sel = ~flags[Z_BIT];
            3'd1: sel =  flags[Z_BIT];
            3'd2: sel = ~flags[C_BIT];
            3'd3: sel =  flags[C_BIT];
            3'd4: sel = ~flags[P_BIT];
            3'd5: sel =  flags[P_BIT];
            3'd6: sel = ~flags[S_BIT];
            3'd7: sel =  flags[S_BIT];
        endcase
        ok = ~cond_en | sel;
    end
endmodule

// File: rtl/brseq_target.sv
module brseq_target
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int B_W    = 8
) (
    input  dec_t              dec,
    input  logic              cond_ok,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] pop_addr,
    input  logic [B_W-1:0]    reg_b,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [1:0]        nbytes,
    output logic              push,
    output logic              pop,
    output logic [ADDR_W-1:0] push_addr,
    output logic [B_W-1:0]    b_new
);
    localparam int DISP_W = 8;

    logic [ADDR_W-1:0] pc1, pc2, pc3, disp_ext, rel_tgt, vec;
    logic [B_W-1:0]    b_dec;

    assign pc1      = pc + ADDR_W'(1);
    assign pc2      = pc + ADDR_W'(2);
    assign pc3      = pc + ADDR_W'(3);
    assign disp_ext = {{(ADDR_W-DISP_W){operand[DISP_W-1]}}, operand[DISP_W-1:0]};
    assign rel_tgt  = pc2 + disp_ext;
    assign vec      = ADDR_W'({dec.cond, 3'b000});
    assign b_dec    = reg_b - B_W'(1);

    always_comb begin
        taken     = 1'b0;
        next_pc   = pc1;
        nbytes    = 2'd0;
        push      = 1'b0;
        pop       = 1'b0;
        push_addr = '0;
        b_new     = reg_b;
        unique case (dec.kind)
            K_JP: begin
                nbytes  = 2'd2;
                taken   = cond_ok;
                next_pc = cond_ok ? operand : pc3;
            end
            K_CALL: begin
                nbytes  = 2'd2;
                taken   = cond_ok;
                push    = cond_ok;
                if (cond_ok) push_addr = pc3;
                next_pc = cond_ok ? operand : pc3;
            end
            K_JR: begin
                nbytes  = 2'd1;
                taken   = cond_ok;
                next_pc = cond_ok ? rel_tgt : pc2;
            end
            K_DJNZ: begin
                nbytes  = 2'd1;
                b_new   = b_dec;
                taken   = (b_dec != '0);
                next_pc = (b_dec != '0) ? rel_tgt : pc2;
            end
            K_RET: begin
                taken   = cond_ok;
                pop     = cond_ok;
                next_pc = cond_ok ? pop_addr : pc1;
            end
            K_RST: begin
                taken     = 1'b1;
                push      = 1'b1;
                push_addr = pc1;
                next_pc   = vec;
            end
            K_JPHL: begin
                taken   = 1'b1;
                next_pc = hl;
            end
            K_NONE: begin
                next_pc = pc1;
            end
        endcase
    end
endmodule

// File: rtl/branch_sequencer.sv
module branch_sequencer
    import brseq_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [7:0]        opcode,
    input  logic [7:0]        flags,
    input  logic [7:0]        reg_b,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] operand,
    input  logic [ADDR_W-1:0] hl,
    input  logic [ADDR_W-1:0] pop_addr,
    output logic              res_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [1:0]        opnd_bytes,
    output logic              push_req,
    output logic              pop_req,
    output logic [ADDR_W-1:0] push_addr,
    output logic [7:0]        b_out
);
    localparam int B_W = 8;

    dec_t              dec;
    logic              cond_ok;
    logic              c_taken, c_push, c_pop;
    logic [ADDR_W-1:0] c_next, c_paddr;
    logic [1:0]        c_bytes;
    logic [B_W-1:0]    c_b;
    state_e            state, state_nx;

    brseq_decode u_dec (
        .op  (opcode),
        .dec (dec)
    );

    brseq_cond u_cond (
        .cond_en (dec.cond_en),
        .cond    (dec.cond),
        .flags   (flags),
        .ok      (cond_ok)
    );

    brseq_target #(.ADDR_W(ADDR_W), .B_W(B_W)) u_tgt (
        .dec       (dec),
        .cond_ok   (cond_ok),
        .pc        (pc),
        .operand   (operand),
        .hl        (hl),
        .pop_addr  (pop_addr),
        .reg_b     (reg_b),
        .taken     (c_taken),
        .next_pc   (c_next),
        .nbytes    (c_bytes),
        .push      (c_push),
        .pop       (c_pop),
        .push_addr (c_paddr),
        .b_new     (c_b)
    );

    // next-state logic: T_ISSUE / T_NEXT / T_DRAIN / T_WAIT
    always_comb begin
        unique case (state)
            ST_IDLE: state_nx = issue ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_nx = issue ? ST_SHOW : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign res_valid = (state == ST_SHOW);

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            next_pc    <= '0;
            opnd_bytes <= 2'd0;
            push_req   <= 1'b0;
            pop_req    <= 1'b0;
            push_addr  <= '0;
            b_out      <= '0;
        end else if (issue) begin
            taken      <= c_taken;
            next_pc    <= c_next;
            opnd_bytes <= c_bytes;
            push_req   <= c_push;
            pop_req    <= c_pop;
            push_addr  <= c_paddr;
            b_out      <= c_b;
        end else begin
            taken      <= 1'b0;
            push_req   <= 1'b0;
            pop_req    <= 1'b0;
        end
    end
endmodule

// File: rtl/branch_sequencer_chk.sv
module branch_sequencer_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue,
    input logic [7:0]        opcode,
    input logic [7:0]        reg_b,
    input logic [ADDR_W-1:0] hl,
    input logic              res_valid,
    input logic              taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic [1:0]        opnd_bytes,
    input logic              push_req,
    input logic              pop_req,
    input logic [7:0]        b_out
);
    // R11
    p_valid_after_issue_r11: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> res_valid);
    p_quiet_after_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> (!res_valid && !taken && !push_req && !pop_req));
    // R6, R8: never push and pop together
    p_stack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_req && pop_req));
    // R3
    p_bytes_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_bytes != 2'd3);
    // R5
    p_loop_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(opcode) == 8'h10) |-> (b_out == $past(reg_b) - 8'd1));
    // R6
    p_rst_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(opcode[7:6]) == 2'b11 && $past(opcode[2:0]) == 3'b111)
        |-> (push_req && next_pc == ADDR_W'({$past(opcode[5:3]), 3'b000})));
    // R8
    p_pop_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req |-> taken);
    // R9
    p_hl_jump_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(opcode) == 8'hE9) |-> (next_pc == $past(hl) && opnd_bytes == 2'd0));
endmodule

bind branch_sequencer branch_sequencer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .opcode     (opcode),
    .reg_b      (reg_b),
    .hl         (hl),
    .res_valid  (res_valid),
    .taken      (taken),
    .next_pc    (next_pc),
    .opnd_bytes (opnd_bytes),
    .push_req   (push_req),
    .pop_req    (pop_req),
    .b_out      (b_out)
);

// File: tb/test_branch_sequencer.sv
`timescale 1ns/1ps
module test_branch_sequencer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue;
    logic [7:0]  opcode, flags, reg_b;
    logic [15:0] pc, operand, hl, pop_addr;
    logic        res_valid, taken, push_req, pop_req;
    logic [15:0] next_pc, push_addr;
    logic [1:0]  opnd_bytes;
    logic [7:0]  b_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // expected values for the stimulus in flight
    bit          e_valid, e_taken, e_push, e_pop;
    int          e_next, e_bytes, e_paddr, e_b;
    string       e_tag;

    always #2.5 clk = ~clk;

    branch_sequencer i_branch_sequencer (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .flags(flags),
        .reg_b(reg_b), .pc(pc), .operand(operand), .hl(hl), .pop_addr(pop_addr),
        .res_valid(res_valid), .taken(taken), .next_pc(next_pc),
        .opnd_bytes(opnd_bytes), .push_req(push_req), .pop_req(pop_req),
        .push_addr(push_addr), .b_out(b_out)
    );

    function automatic bit cond_holds(int c, logic [7:0] f);
        case (c)
            0: return f[6] == 1'b0;
            1: return f[6] == 1'b1;
            2: return f[0] == 1'b0;
            3: return f[0] == 1'b1;
            4: return f[2] == 1'b0;
            5: return f[2] == 1'b1;
            6: return f[7] == 1'b0;
            default: return f[7] == 1'b1;
        endcase
    endfunction

    // behavioural model of one resolved instruction
    task automatic model(input logic [7:0] op, input logic [7:0] f, input int b,
                         input int p, input int opn, input int h, input int pa);
        int  c;
        int  disp;
        bit  ok;
        disp = (opn & 8'hFF);
        if (disp > 127) disp = disp - 256;
        e_valid = 1; e_taken = 0; e_push = 0; e_pop = 0;
        e_next = (p + 1) % 65536; e_bytes = 0; e_paddr = 0; e_b = b;
        c = (op >> 3) & 7;
        if (op == 8'hC3 || (op & 8'hC7) == 8'hC2) begin
            ok = (op == 8'hC3) ? 1'b1 : cond_holds(c, f);
            e_bytes = 2; e_taken = ok;
            e_next = ok ? opn : (p + 3) % 65536;
            e_tag = ok ? "R2" : "R3";
        end else if (op == 8'hCD || (op & 8'hC7) == 8'hC4) begin
            ok = (op == 8'hCD) ? 1'b1 : cond_holds(c, f);
            e_bytes = 2; e_taken = ok; e_push = ok;
            e_paddr = ok ? (p + 3) % 65536 : 0;
            e_next = ok ? opn : (p + 3) % 65536;
            e_tag = ok ? "R7" : "R3";
        end else if (op == 8'hC9 || (op & 8'hC7) == 8'hC0) begin
            ok = (op == 8'hC9) ? 1'b1 : cond_holds(c, f);
            e_taken = ok; e_pop = ok;
            e_next = ok ? pa : (p + 1) % 65536;
            e_tag = "R8";
        end else if ((op & 8'hC7) == 8'hC7) begin
            e_taken = 1; e_push = 1; e_paddr = (p + 1) % 65536;
            e_next = c * 8;
            e_tag = "R6";
        end else if (op == 8'hE9) begin
            e_taken = 1; e_next = h;
            e_tag = "R9";
        end else if (op == 8'h18 || (op & 8'hE7) == 8'h20) begin
            ok = (op == 8'h18) ? 1'b1 : cond_holds(c & 3, f);
            e_bytes = 1; e_taken = ok;
            e_next = ok ? (p + 2 + disp + 65536) % 65536 : (p + 2) % 65536;
            e_tag = "R4";
        end else if (op == 8'h10) begin
            e_b = (b + 255) % 256;
            e_bytes = 1; e_taken = (e_b != 0);
            e_next = e_taken ? (p + 2 + disp + 65536) % 65536 : (p + 2) % 65536;
            e_tag = "R5";
        end else begin
            e_tag = "R10";
        end
    endtask

    task automatic compare();
        bit bad;
        checks++;
        if (!e_valid) begin
            bad = (res_valid !== 1'b0) || (taken !== 1'b0) || (push_req !== 1'b0) || (pop_req !== 1'b0);
            if (bad) begin
                errors++;
                $display("FAIL %s: valid/taken/push/pop = %b%b%b%b expected 0000",
                         e_tag, res_valid, taken, push_req, pop_req);
            end
        end else begin
            bad = (res_valid !== 1'b1) || (taken !== e_taken) || (int'(next_pc) != e_next) ||
                  (int'(opnd_bytes) != e_bytes) || (push_req !== e_push) || (pop_req !== e_pop) ||
                  (int'(push_addr) != e_paddr) || (int'(b_out) != e_b);
            if (bad) begin
                errors++;
                $display("FAIL %s op=%h: got v%b t%b pc=%h n=%0d push=%b pop=%b pa=%h b=%h ; expected v1 t%b pc=%h n=%0d push=%b pop=%b pa=%h b=%h",
                         e_tag, opcode, res_valid, taken, next_pc, opnd_bytes, push_req, pop_req,
                         push_addr, b_out, e_taken, e_next[15:0], e_bytes, e_push, e_pop,
                         e_paddr[15:0], e_b[7:0]);
            end
        end
    endtask

    // drive one cycle of stimulus, then check one cycle later at the falling edge
    task automatic step(input bit iss, input logic [7:0] op, input logic [7:0] f,
                        input logic [7:0] b, input logic [15:0] p, input logic [15:0] opn,
                        input logic [15:0] h, input logic [15:0] pa);
        issue = iss; opcode = op; flags = f; reg_b = b; pc = p; operand = opn;
        hl = h; pop_addr = pa;
        if (iss) model(op, f, int'(b), int'(p), int'(opn), int'(h), int'(pa));
        else begin e_valid = 0; e_tag = "R11"; end
        @(negedge clk);
        compare();
    endtask

    logic [7:0] pool [16];

    initial begin
        pool = '{8'hC3, 8'hC2, 8'hE2, 8'hFA, 8'hCD, 8'hDC, 8'hF4, 8'hC9,
                 8'hC0, 8'hE8, 8'hFF, 8'hD7, 8'hE9, 8'h18, 8'h38, 8'h10};
        rst_n = 0; issue = 0; opcode = 0; flags = 0; reg_b = 0;
        pc = 0; operand = 0; hl = 0; pop_addr = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (res_valid !== 0 || taken !== 0 || push_req !== 0 || pop_req !== 0 ||
            next_pc !== 0 || push_addr !== 0 || b_out !== 0 || opnd_bytes !== 0) begin
            errors++;
            $display("FAIL R1: valid=%b taken=%b push=%b pop=%b pc=%h expected all zero",
                     res_valid, taken, push_req, pop_req, next_pc);
        end
        rst_n = 1;
        // R2: every condition on JP cc, with each flag set and clear
        for (int c = 0; c < 8; c++) begin
            step(1, 8'hC2 | 8'(c << 3), 8'h00, 8'h05, 16'h1000, 16'hBEEF, 16'h0, 16'h0);
            step(1, 8'hC2 | 8'(c << 3), 8'hC5, 8'h05, 16'h1000, 16'hBEEF, 16'h0, 16'h0);
        end
        step(1, 8'hC3, 8'h00, 8'h05, 16'hFFFE, 16'h4321, 16'h0, 16'h0);   // R2 unconditional
        step(1, 8'hCA, 8'h00, 8'h05, 16'hFFFE, 16'h4321, 16'h0, 16'h0);   // R3 wrap pc+3
        step(1, 8'hCC, 8'h00, 8'h05, 16'h2000, 16'h4321, 16'h0, 16'h0);   // R3 call not taken
        step(1, 8'hCD, 8'h00, 8'h05, 16'h2000, 16'h4321, 16'h0, 16'h0);   // R7
        step(1, 8'hEC, 8'h04, 8'h05, 16'h2000, 16'h0777, 16'h0, 16'h0);   // R7 on parity
        // R4 relative, positive / negative / boundary displacements
        step(1, 8'h18, 8'h00, 8'h05, 16'h3000, 16'h007F, 16'h0, 16'h0);
        step(1, 8'h18, 8'h00, 8'h05, 16'h3000, 16'h0080, 16'h0, 16'h0);
        step(1, 8'h18, 8'h00, 8'h05, 16'h0000, 16'h00FE, 16'h0, 16'h0);
        step(1, 8'h28, 8'h00, 8'h05, 16'h3000, 16'h0010, 16'h0, 16'h0);
        step(1, 8'h38, 8'h01, 8'h05, 16'h3000, 16'h00F0, 16'h0, 16'h0);
        step(1, 8'h30, 8'h01, 8'h05, 16'h3000, 16'h00F0, 16'h0, 16'h0);
        // R5 loop branch: B = 2, 1, 0
        step(1, 8'h10, 8'h00, 8'h02, 16'h4000, 16'h00FC, 16'h0, 16'h0);
        step(1, 8'h10, 8'h00, 8'h01, 16'h4000, 16'h00FC, 16'h0, 16'h0);
        step(1, 8'h10, 8'h00, 8'h00, 16'h4000, 16'h00FC, 16'h0, 16'h0);
        // R6 all restart vectors
        for (int t = 0; t < 8; t++)
            step(1, 8'hC7 | 8'(t << 3), 8'h00, 8'h05, 16'h5555, 16'h0, 16'h0, 16'h0);
        // R8 returns
        step(1, 8'hC9, 8'h00, 8'h05, 16'h6000, 16'h0, 16'h0, 16'hABCD);
        step(1, 8'hC8, 8'h00, 8'h05, 16'h6000, 16'h0, 16'h0, 16'hABCD);
        step(1, 8'hF8, 8'h80, 8'h05, 16'h6000, 16'h0, 16'h0, 16'hABCD);
        // R9 jump through HL
        step(1, 8'hE9, 8'h00, 8'h05, 16'h7000, 16'h1111, 16'h8642, 16'h0);
        // R10 non-branch opcodes
        step(1, 8'h00, 8'hFF, 8'h05, 16'h7000, 16'h1111, 16'h0, 16'h0);
        step(1, 8'h08, 8'hFF, 8'h05, 16'hFFFF, 16'h1111, 16'h0, 16'h0);
        step(1, 8'hC5, 8'hFF, 8'h05, 16'h7000, 16'h1111, 16'h0, 16'h0);
        // R11 idle cycles
        step(0, 8'hC3, 8'h00, 8'h05, 16'h7000, 16'h1111, 16'h0, 16'h0);
        step(0, 8'hC3, 8'h00, 8'h05, 16'h7000, 16'h1111, 16'h0, 16'h0);
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            step(($urandom_range(0, 7) != 0), pool[$urandom_range(0, 15)],
                 8'($urandom), 8'($urandom_range(0, 3)), 16'($urandom), 16'($urandom),
                 16'($urandom), 16'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule